// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block is the master side of a three-wire serial link: a clock output, one data line shared by both directions, and an active-low chip select. A user starts a transaction with a one-cycle `start`, an operation code, a register address and a write byte. The block then runs the whole exchange inside one chip-select-low window and drops back to idle. It supports a single-register write, a single-register read, and a short motion burst that fetches two bytes and then ends the burst early by releasing chip select.

The data pin is split into `sdo`, `sdo_oe` and `sdi` so that the pad cell outside the block forms the bidirectional line. The block drives the line only while it sends address and write bits. It releases the line for turnaround gaps and for read bits. Every phase length is a whole number of microseconds. The number of system clocks per microsecond is a parameter, so the same logic serves any system clock.

Top module: `tw_serial_master`

## Requirements
- R1: While reset is asserted and just after it is released, `cs_n` and `sclk` are 1, `sdo_oe`, `busy` and `done` are 0, and `rd_x` and `rd_y` are zero.
- R2: A `start` with `op` = 0 (write) runs the following inside one chip-select-low window: the address byte with bit 7 forced to 1, then `wdata`. Each byte is sent most-significant bit first. For each bit, `sclk` is low for WR_LOW_US microseconds with the bit driven on `sdo` (`sdo_oe` = 1), then high for WR_HIGH_US microseconds with the bit held.
- R3: A `start` with `op` = 1 (read) sends the address with bit 7 clear. It then clocks in one byte: `sclk` low for RD_LOW_US, then high for RD_HIGH_US, with `sdo_oe` at 0. `sdi` is sampled in the last system clock of each low phase, MSB first. The byte lands in `rd_x`, and `rd_y` keeps its value.
- R4: A `start` with `op` = 2 (burst) sends the fixed address BURST_ADDR (default 0x63), reads two bytes into `rd_x` (first) and `rd_y` (second), and then releases chip select.
- R5: After every transmitted byte, `sclk` stays high and `sdo_oe` stays 0 for TURN_US microseconds before the next phase or the release. After the last received byte, `cs_n` stays low with `sclk` high for HOLD_US microseconds.
- R6: `busy` is 1 from the cycle after an accepted `start` until the last cycle with `cs_n` low. `done` is a one-cycle pulse in the first cycle that `cs_n` is high again.
- R7: A `start` that arrives while `busy` is 1 has no effect on the running transaction or on the read results.
- R8: A `start` with `op` = 3 is not accepted: `busy` stays 0 and nothing on the link moves.
- R9: Between transactions, `sclk` and `cs_n` are high and `sdo_oe` is 0. Every phase lasts exactly its microsecond count times CLKS_PER_US system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request to begin a transaction |
| op | input | 2 | Operation: 0 write, 1 read, 2 burst, 3 reserved |
| addr | input | DATA_W-1 | Register address (flag bit added by the block) |
| wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when chip select is released |
| rd_x | output | DATA_W | Read byte, or first burst byte |
| rd_y | output | DATA_W | Second burst byte |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| sdo | output | 1 | Data toward the line |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| sdi | input | 1 | Data sampled from the shared line |

## Verification
The bench builds the block with CLKS_PER_US = 3 and keeps the default microsecond counts. Each microsecond is therefore three system clocks. A burst then takes under two hundred cycles, so every phase boundary, both bytes of a burst and back-to-back transactions can be compared cycle by cycle. Three clocks per microsecond also means a sampling point that is off by one system clock lands on the wrong bit in the reference comparison. A timer that miscounts a phase shifts every later cycle of the expected waveform.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [1:0] {
    OP_WR    = 2'd0,
    OP_RD    = 2'd1,
    OP_BURST = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TX_LO = 3'd1,
    ST_TX_HI = 3'd2,
    ST_GAP   = 3'd3,
    ST_RX_LO = 3'd4,
    ST_RX_HI = 3'd5,
    ST_HOLD  = 3'd6
  } st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tws_us_timer.sv
module tws_us_timer #(
  parameter int CLKS_PER_US = 50,
  parameter int US_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  localparam int MAX_CNT = ((1 << US_W) - 1) * CLKS_PER_US;
  localparam int CW      = $clog2(MAX_CNT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CW'(int'(load_us) * CLKS_PER_US - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[W-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q;

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              US_W       = 3,
  parameter int              WR_LOW_US  = 2,
  parameter int              WR_HIGH_US = 1,
  parameter int              RD_LOW_US  = 1,
  parameter int              RD_HIGH_US = 1,
  parameter int              TURN_US    = 4,
  parameter int              HOLD_US    = 1,
  parameter logic [DATA_W-1:0] BURST_ADDR = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-2:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tmr_exp,
  output logic              tmr_load,
  output logic [US_W-1:0]   tmr_us,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_val,
  output logic              sh_shift,
  output logic              cap_x,
  output logic              cap_y,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdo_oe
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  st_e             st_q, st_d;
  op_e             op_q, op_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic            second_q, second_d;
  logic            done_q, done_d;
  op_e             op_in;

  assign op_in = op_e'(op);

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    bit_d    = bit_q;
    second_d = second_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_us   = '0;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    cap_x    = 1'b0;
    cap_y    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && (op_in != OP_RSVD)) begin
          op_d     = op_in;
          bit_d    = '0;
          second_d = 1'b0;
          st_d     = ST_TX_LO;
          tmr_load = 1'b1;
          tmr_us   = US_W'(WR_LOW_US);
          sh_load  = 1'b1;
          case (op_in)
            OP_WR:   sh_val = {1'b1, addr};
            OP_RD:   sh_val = {1'b0, addr};
            default: sh_val = BURST_ADDR;
          endcase
        end
      end
      ST_TX_LO: begin
        if (tmr_exp) begin
          st_d     = ST_TX_HI;
          tmr_load = 1'b1;
          tmr_us   = US_W'(WR_HIGH_US);
        end
      end
      ST_TX_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            st_d   = ST_GAP;
            tmr_us = US_W'(TURN_US);
          end else begin
            bit_d    = bit_q + 1'b1;
            sh_shift = 1'b1;
            st_d     = ST_TX_LO;
            tmr_us   = US_W'(WR_LOW_US);
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          bit_d = '0;
          if (op_q == OP_WR) begin
            if (!second_q) begin
              second_d = 1'b1;
              sh_load  = 1'b1;
              sh_val   = wdata;
              st_d     = ST_TX_LO;
              tmr_load = 1'b1;
              tmr_us   = US_W'(WR_LOW_US);
            end else begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end else begin
            second_d = 1'b0;
            st_d     = ST_RX_LO;
            tmr_load = 1'b1;
            tmr_us   = US_W'(RD_LOW_US);
          end
        end
      end
      ST_RX_LO: begin
        if (tmr_exp) begin
          sh_shift = 1'b1;
          st_d     = ST_RX_HI;
          tmr_load = 1'b1;
          tmr_us   = US_W'(RD_HIGH_US);
        end
      end
      ST_RX_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            cap_x = !second_q;
            cap_y = second_q;
            bit_d = '0;
            if ((op_q == OP_BURST) && !second_q) begin
              second_d = 1'b1;
              st_d     = ST_RX_LO;
              tmr_us   = US_W'(RD_LOW_US);
            end else begin
              st_d   = ST_HOLD;
              tmr_us = US_W'(HOLD_US);
            end
          end else begin
            bit_d  = bit_q + 1'b1;
            st_d   = ST_RX_LO;
            tmr_us = US_W'(RD_LOW_US);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_WR;
      bit_q    <= '0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      bit_q    <= bit_d;
      second_q <= second_d;
      done_q   <= done_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign cs_n   = (st_q == ST_IDLE);
  assign sclk   = !((st_q == ST_TX_LO) || (st_q == ST_RX_LO));
  assign sdo_oe = (st_q == ST_TX_LO) || (st_q == ST_TX_HI);
  assign done   = done_q;

endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import tws_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                CLKS_PER_US = 50,
  parameter int                WR_LOW_US   = 2,
  parameter int                WR_HIGH_US  = 1,
  parameter int                RD_LOW_US   = 1,
  parameter int                RD_HIGH_US  = 1,
  parameter int                TURN_US     = 4,
  parameter int                HOLD_US     = 1,
  parameter logic [DATA_W-1:0] BURST_ADDR  = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-2:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_x,
  output logic [DATA_W-1:0] rd_y,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);
  localparam int MAX_US = max_of(max_of(max_of(WR_LOW_US, WR_HIGH_US),
                                        max_of(RD_LOW_US, RD_HIGH_US)),
                                 max_of(TURN_US, HOLD_US));
  localparam int US_W = $clog2(MAX_US + 1);

  logic              tmr_load, tmr_exp;
  logic [US_W-1:0]   tmr_us;
  logic              sh_load, sh_shift, cap_x, cap_y;
  logic [DATA_W-1:0] sh_val, sh_q;
  logic [DATA_W-1:0] rd_x_q, rd_x_d, rd_y_q, rd_y_d;

  tws_us_timer #(
    .CLKS_PER_US(CLKS_PER_US),
    .US_W       (US_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .load_us(tmr_us),
    .expired(tmr_exp)
  );

  tws_shifter #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .load_val(sh_val),
    .shift   (sh_shift),
    .in_bit  (sdi),
    .q       (sh_q)
  );

  tws_ctrl #(
    .DATA_W    (DATA_W),
    .US_W      (US_W),
    .WR_LOW_US (WR_LOW_US),
    .WR_HIGH_US(WR_HIGH_US),
    .RD_LOW_US (RD_LOW_US),
    .RD_HIGH_US(RD_HIGH_US),
    .TURN_US   (TURN_US),
    .HOLD_US   (HOLD_US),
    .BURST_ADDR(BURST_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .addr    (addr),
    .wdata   (wdata),
    .tmr_exp (tmr_exp),
    .tmr_load(tmr_load),
    .tmr_us  (tmr_us),
    .sh_load (sh_load),
    .sh_val  (sh_val),
    .sh_shift(sh_shift),
    .cap_x   (cap_x),
    .cap_y   (cap_y),
    .busy    (busy),
    .done    (done),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sdo_oe  (sdo_oe)
  );

  always_comb begin
    rd_x_d = cap_x ? sh_q : rd_x_q;
    rd_y_d = cap_y ? sh_q : rd_y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_x_q <= '0;
      rd_y_q <= '0;
    end else begin
      rd_x_q <= rd_x_d;
      rd_y_q <= rd_y_d;
    end
  end

  assign rd_x = rd_x_q;
  assign rd_y = rd_y_q;
  assign sdo  = sh_q[DATA_W-1];

endmodule

// File: rtl/tws_master_chk.sv
module tws_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic       done,
  input logic       sclk,
  input logic       cs_n,
  input logic       sdo,
  input logic       sdo_oe
);

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk && !sdo_oe));

  // R9
  sclk_fall_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);

  // R6
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_matches_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op != 2'd3)) |=> busy);

  // R8
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op == 2'd3)) |=> !busy);

  // R2
  sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sclk && $past(sdo_oe) && $past(sclk)) |-> $stable(sdo));

  // R5
  release_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) && !$past(sdo_oe)));

endmodule

bind tw_serial_master tws_master_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .op    (op),
  .busy  (busy),
  .done  (done),
  .sclk  (sclk),
  .cs_n  (cs_n),
  .sdo   (sdo),
  .sdo_oe(sdo_oe)
);

// File: tb/tw_serial_master_test.sv
`timescale 1ns/1ps
module tw_serial_master_test;
  localparam int C      = 3;
  localparam int P_WLO  = 2 * C;
  localparam int P_WHI  = 1 * C;
  localparam int P_RLO  = 1 * C;
  localparam int P_RHI  = 1 * C;
  localparam int P_TURN = 4 * C;
  localparam int P_HOLD = 1 * C;

  logic       clk, rst_n, start, sdi;
  logic [1:0] op;
  logic [6:0] addr;
  logic [7:0] wdata, rd_x, rd_y;
  logic       busy, done, sclk, cs_n, sdo, sdo_oe;

  int checks = 0;
  int fails  = 0;
  int q_exp[$];
  int fall_cnt = 0;
  int rise_cnt = 0;
  logic [15:0] slave_word = 16'h0;
  logic [15:0] cap = 16'h0;
  logic [7:0]  exp_x = 8'h0;
  logic [7:0]  exp_y = 8'h0;

  tw_serial_master #(.CLKS_PER_US(C)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .rd_x(rd_x), .rd_y(rd_y),
    .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: shifts read bits out on falling sclk, captures on rising sclk
  always @(negedge sclk) begin
    if (fall_cnt >= 8 && fall_cnt < 24) sdi <= slave_word[15 - (fall_cnt - 8)];
    fall_cnt <= fall_cnt + 1;
  end
  always @(posedge sclk) begin
    if (rise_cnt < 16) cap <= {cap[14:0], sdo};
    rise_cnt <= rise_cnt + 1;
  end

  // entry: [0]cs [1]sclk [2]oe [4:3]sdo(2=any) [5]done [15:8]req
  task automatic push(input int n, input int cs, input int sc, input int oe,
                      input int so, input int dn, input int req);
    for (int i = 0; i < n; i++)
      q_exp.push_back(cs | (sc << 1) | (oe << 2) | (so << 3) | (dn << 5) | (req << 8));
  endtask

  task automatic tx_byte(input logic [7:0] b, input int req);
    for (int i = 7; i >= 0; i--) begin
      push(P_WLO, 0, 0, 1, int'(b[i]), 0, req);
      push(P_WHI, 0, 1, 1, int'(b[i]), 0, req);
    end
    push(P_TURN, 0, 1, 0, 2, 0, 5);
  endtask

  task automatic rx_byte(input int req);
    for (int i = 0; i < 8; i++) begin
      push(P_RLO, 0, 0, 0, 2, 0, req);
      push(P_RHI, 0, 1, 0, 2, 0, req);
    end
  endtask

  // cycle-by-cycle comparison against the reference queue
  initial begin
    int e, req, exp_v, act_v;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #5;
      if (q_exp.size() != 0) e = q_exp.pop_front();
      else e = 1 | (1 << 1) | (2 << 3) | (9 << 8);
      req   = (e >> 8) & 8'hff;
      exp_v = (e & 7) | ((((e & 1) == 0) ? 1 : 0) << 3) | (((e >> 5) & 1) << 4);
      act_v = int'(cs_n) | (int'(sclk) << 1) | (int'(sdo_oe) << 2) |
              (int'(busy) << 3) | (int'(done) << 4);
      if (((e >> 3) & 3) != 2) begin
        exp_v = exp_v | (((e >> 3) & 1) << 5);
        act_v = act_v | (int'(sdo) << 5);
      end
      check(act_v == exp_v, $sformatf("R%0d waveform", req), act_v, exp_v);
    end
  end

  task automatic run_op(input int opc, input logic [6:0] a, input logic [7:0] wd,
                        input logic [7:0] sx, input logic [7:0] sy, input bit poke);
    @(negedge clk);
    fall_cnt   = 0;
    rise_cnt   = 0;
    slave_word = {sx, sy};
    start = 1'b1; op = 2'(opc); addr = a; wdata = wd;
    case (opc)
      0: begin tx_byte({1'b1, a}, 2); tx_byte(wd, 2); end
      1: begin tx_byte({1'b0, a}, 3); rx_byte(3); push(P_HOLD, 0, 1, 0, 2, 0, 5); end
      default: begin tx_byte(8'h63, 4); rx_byte(4); rx_byte(4); push(P_HOLD, 0, 1, 0, 2, 0, 5); end
    endcase
    push(1, 1, 1, 0, 2, 1, 6);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; op = 2'd2; addr = 7'h55;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R7 busy during ignored start", int'(busy), 1);
    end
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
    if (opc == 0) begin
      check(cap == {1'b1, a, wd}, "R2 bytes seen by slave", int'(cap), int'({1'b1, a, wd}));
    end else if (opc == 1) begin
      exp_x = sx;
      check(cap[15:8] == {1'b0, a}, "R3 address seen by slave", int'(cap[15:8]), int'({1'b0, a}));
      check(rd_x == exp_x, "R3 read byte", int'(rd_x), int'(exp_x));
      check(rd_y == exp_y, "R3 rd_y unchanged", int'(rd_y), int'(exp_y));
    end else begin
      exp_x = sx; exp_y = sy;
      check(cap[15:8] == 8'h63, "R4 burst address", int'(cap[15:8]), 8'h63);
      check(rd_x == exp_x, "R4 first burst byte", int'(rd_x), int'(exp_x));
      check(rd_y == exp_y, "R4 second burst byte", int'(rd_y), int'(exp_y));
    end
    if (poke) check(rd_x == exp_x && rd_y == exp_y, "R7 results untouched",
                    int'({rd_x, rd_y}), int'({exp_x, exp_y}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'd0; addr = 7'h0; wdata = 8'h0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cs_n && sclk && !sdo_oe && !busy && !done, "R1 reset lines",
          int'({cs_n, sclk, sdo_oe, busy, done}), 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_x == 8'h0 && rd_y == 8'h0, "R1 reset results", int'({rd_x, rd_y}), 0);
    check(cs_n && sclk && !sdo_oe && !busy, "R1 after release",
          int'({cs_n, sclk, sdo_oe, busy}), 4'b1100);

    run_op(0, 7'h19, 8'h1D, 8'h00, 8'h00, 1'b0);
    run_op(1, 7'h05, 8'h00, 8'hA5, 8'h00, 1'b0);
    run_op(1, 7'h7F, 8'h00, 8'hFF, 8'h00, 1'b0);
    run_op(2, 7'h00, 8'h00, 8'h81, 8'h7E, 1'b0);
    run_op(0, 7'h0D, 8'hC3, 8'h00, 8'h00, 1'b1);
    run_op(1, 7'h22, 8'h00, 8'h01, 8'h00, 1'b1);

    // R8: reserved op
    @(negedge clk);
    start = 1'b1; op = 2'd3;
    @(negedge clk);
    start = 1'b0;
    check(!busy && cs_n, "R8 reserved op not accepted", int'({busy, cs_n}), 2'b01);
    repeat (6) @(negedge clk);
    check(!busy && sclk && rd_x == exp_x, "R8 nothing moved", int'({busy, sclk, rd_x}),
          int'({1'b0, 1'b1, exp_x}));

    run_op(2, 7'h00, 8'h00, 8'hFF, 8'h00, 1'b0);
    run_op(2, 7'h00, 8'h00, 8'h3C, 8'hC3, 1'b0);
    run_op(1, 7'h00, 8'h00, 8'h5A, 8'h00, 1'b0);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule